// File: doc/BRIEF.md
# Asynchronous Disk Read Data Register

This block turns the self-clocked serial read stream of a floppy-style drive into bytes that a host collects over an 8-bit bus. The serial line is asynchronous to the block clock. After a two-flop synchronizer, every falling edge counts as a flux transition and yields a 1 bit. A bit-cell timer restarts on each transition and inserts a 0 bit whenever a whole cell passes with no transition. The recovered bits enter a shift register, and a byte is complete once a 1 reaches its top bit. The completed byte is then copied into the host-visible data register, and the shifter starts again from zero. Because every byte therefore has its top bit set, that bit works as a "byte ready" flag.

A three-bit mode register sets the timing base and the read policy. The host writes it by pulling the device select low while both qualifier lines are high. With the fast bit set, the timing base ticks on every clock. With it clear, the timing base ticks on every second clock. When the asynchronous and latch bits are both set, a host read keeps the byte for a fixed number of clocks and then clears it. Under any other setting, the byte stays until the first 1 of the next byte enters the shifter. With device select held low and the qualifiers at zero, the bus follows the data register without a break. The top bit then serves as a strobe for latching bytes externally. Before the top bit rises again, it always stays low for a guaranteed minimum time.

The data register is run by a state machine with four states:
- ST_IDLE: the register is clear.
- ST_WAIT: the register is clear and a finished byte waits for the minimum low time to pass.
- ST_VALID: the register holds a byte.
- ST_HOLD: the latch-policy hold after a read.

Its transitions are:
- ST_IDLE→ST_VALID on byte completion once the low time has passed.
- ST_IDLE→ST_WAIT on byte completion before the low time has passed.
- ST_WAIT→ST_VALID when the low time has passed.
- ST_VALID→ST_HOLD on the start of a read under the latch policy.
- ST_VALID→ST_IDLE on the start of the next byte when the latch policy is off.
- ST_VALID→ST_WAIT or ST_HOLD→ST_WAIT on completion of a new byte that overwrites the old one.
- ST_HOLD→ST_IDLE when the hold count expires.

Top module: `disk_rdreg`

## Requirements
- R1: After reset the mode register is 0 (slow timing, synchronous mode, latch off) and the data register is empty, so a read returns 8'h00.
- R2: The mode register loads `mode_wdata` on a clock edge only while `dev_sel_n` is low and both `qual_a` and `qual_b` are high. Its fields are bit 0 latch, bit 1 asynchronous and bit 2 fast. It keeps its value with any other combination of the qualifiers.
- R3: `rd_data` equals the data register while `dev_sel_n` is low and `qual_a`/`qual_b` are both 0. Otherwise `rd_data` is 8'h00.
- R4: A falling edge on `rd_serial` gives a 1 bit and restarts the cell timer. A 0 bit is inserted after CELL_TICKS ticks with no transition. Bits enter MSB first. A byte completes when a 1 reaches bit 7. In fast mode a falling edge that completes a byte shows in the data register after the third rising clock edge, counted from the edge at which the low level is first sampled.
- R5: The tick rate follows the fast bit: one tick per clock when the bit is 1, one tick every two clocks when it is 0.
- R6: When the asynchronous and latch bits are both 1, a read that begins while a byte is held starts a hold. The byte stays visible for HOLD_CYC clocks, counted from the first rising edge of the read, and is then cleared. Under this policy the start of the next byte does not clear the register.
- R7: When the latch policy is off, the held byte is cleared on the edge at which the first 1 bit of the next byte enters the shifter. This includes continuous port operation with select held low.
- R8: Once bit 7 of the data register falls, it stays low for at least LOW_MIN clocks before it rises again. A byte that completes earlier is kept back until this time has passed.
- R9: A byte that completes while an earlier byte is still held clears the register on that edge. The new byte then appears exactly LOW_MIN clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_serial | input | 1 | Asynchronous serial read line, falling edge = transition |
| dev_sel_n | input | 1 | Device select, active low |
| qual_a | input | 1 | Register-access qualifier A |
| qual_b | input | 1 | Register-access qualifier B |
| mode_wdata | input | 3 | Mode write data: bit 2 fast, bit 1 async, bit 0 latch |
| rd_data | output | 8 | Host read data |

## Verification
A falling edge on the serial line reaches the shifter on the third rising clock edge in fast mode. A byte-ending or byte-starting bit therefore changes `rd_data` after that edge. The directed check samples one falling edge earlier and one later to bracket it. A latch-policy hold lasts HOLD_CYC edges from the first edge of the read, and an overwrite gap lasts exactly LOW_MIN edges. Both are checked at the negative edges on either side of the expected change. The scoreboard monitor samples two nanoseconds after each rising edge. It pops one expected byte per rise of bit 7, measures the low run in clocks, and so does not depend on the exact latency of the bit stream.

// File: rtl/rdreg_pkg.sv
package rdreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_VALID = 2'd2,
        ST_HOLD  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic fast;
        logic async_on;
        logic latch;
    } mode_t;

endpackage

// File: rtl/rdreg_sync_edge.sv
module rdreg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[STAGES-1:0], din};
    end

    assign fall = hist_q[STAGES] & ~hist_q[STAGES-1];
endmodule

// File: rtl/rdreg_cell_timer.sv
module rdreg_cell_timer #(
    parameter int CELL_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic fall,
    output logic bit_vld,
    output logic bit_val
);
    localparam int CW = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;

    logic          div_q;
    logic          pend_q;
    logic [CW-1:0] cnt_q;
    logic          tick, trans, expire;

    assign tick   = fast | div_q;
    assign trans  = tick & (pend_q | fall);
    assign expire = tick & ~trans & (cnt_q == CW'(CELL_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            div_q  <= ~div_q;
            pend_q <= (pend_q | fall) & ~tick;
            if (tick) cnt_q <= (trans | expire) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_vld = trans | expire;
    assign bit_val = trans;
endmodule

// File: rtl/rdreg_shifter.sv
module rdreg_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_vld,
    input  logic          bit_val,
    output logic          byte_done,
    output logic          shift_start,
    output logic [DW-1:0] byte_val
);
    logic [DW-2:0] sh_q;

    assign byte_val    = {sh_q, bit_val};
    assign byte_done   = bit_vld & byte_val[DW-1];
    assign shift_start = bit_vld & bit_val & (sh_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sh_q <= '0;
        else if (bit_vld) sh_q <= byte_done ? '0 : byte_val[DW-2:0];
    end
endmodule

// File: rtl/disk_rdreg.sv
module disk_rdreg
    import rdreg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CELL_TICKS  = 8,
    parameter int LOW_MIN     = 6,
    parameter int HOLD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_serial,
    input  logic          dev_sel_n,
    input  logic          qual_a,
    input  logic          qual_b,
    input  logic [2:0]    mode_wdata,
    output logic [DW-1:0] rd_data
);
    localparam int LCW = $clog2(LOW_MIN + 1);
    localparam int HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic          fall, bit_vld, bit_val, byte_done, shift_start;
    logic [DW-1:0] byte_val;

    rdreg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_serial), .fall(fall)
    );

    rdreg_cell_timer #(.CELL_TICKS(CELL_TICKS)) u_cell (
        .clk(clk), .rst_n(rst_n), .fast(mode_q.fast), .fall(fall),
        .bit_vld(bit_vld), .bit_val(bit_val)
    );

    rdreg_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .byte_done(byte_done), .shift_start(shift_start), .byte_val(byte_val)
    );

    mode_t          mode_q;
    rd_state_e      st_q, st_d;
    logic [DW-1:0]  data_q, pend_q;
    logic [HCW-1:0] hcnt_q;
    logic [LCW-1:0] lowcnt_q;
    logic           rd_acc, rd_acc_q, rd_start, mode_we;
    logic           latch_pol, low_ok, hold_done;
    logic           load_new, load_pend, save_pend, clr;

    assign rd_acc    = ~dev_sel_n & ~qual_a & ~qual_b;
    assign mode_we   = ~dev_sel_n & qual_a & qual_b;
    assign rd_start  = rd_acc & ~rd_acc_q;
    assign latch_pol = mode_q.async_on & mode_q.latch;
    assign low_ok    = (lowcnt_q >= LCW'(LOW_MIN - 1));
    assign hold_done = (hcnt_q == HCW'(HOLD_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and datapath controls
    always_comb begin
        st_d      = st_q;
        load_new  = 1'b0;
        load_pend = 1'b0;
        save_pend = 1'b0;
        clr       = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_WAIT: begin
                if (byte_done && low_ok) begin
                    load_new = 1'b1;
                    st_d     = ST_VALID;
                end else if (byte_done) begin
                    save_pend = 1'b1;
                    st_d      = ST_WAIT;
                end else if (st_q == ST_WAIT && low_ok) begin
                    load_pend = 1'b1;
                    st_d      = ST_VALID;
                end
            end
            ST_VALID: begin
                if (byte_done) begin
                    clr       = 1'b1;
                    save_pend = 1'b1;
                    st_d      = ST_WAIT;
                end else if (latch_pol && rd_start) begin
                    st_d = ST_HOLD;
                end else if (!latch_pol && shift_start) begin
                    clr  = 1'b1;
                    st_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (byte_done) begin
                    clr       = 1'b1;
                    save_pend = 1'b1;
                    st_d      = ST_WAIT;
                end else if (hold_done) begin
                    clr  = 1'b1;
                    st_d = ST_IDLE;
                end
            end
        endcase
    end

    // registers beside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            data_q   <= '0;
            pend_q   <= '0;
            hcnt_q   <= '0;
            lowcnt_q <= LCW'(LOW_MIN);
            rd_acc_q <= 1'b0;
        end else begin
            rd_acc_q <= rd_acc;
            if (mode_we)   mode_q <= mode_t'(mode_wdata);
            if (save_pend) pend_q <= byte_val;
            if (load_new)       data_q <= byte_val;
            else if (load_pend) data_q <= pend_q;
            else if (clr)       data_q <= '0;
            if (st_q == ST_HOLD) hcnt_q <= hcnt_q + 1'b1;
            else                 hcnt_q <= '0;
            if (data_q[DW-1])                 lowcnt_q <= '0;
            else if (lowcnt_q != LCW'(LOW_MIN)) lowcnt_q <= lowcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        rd_data = rd_acc ? data_q : '0;
    end
endmodule

// File: rtl/rdreg_chk.sv
module rdreg_chk
    import rdreg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int LOW_MIN = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_sel_n,
    input logic          qual_a,
    input logic          qual_b,
    input logic [2:0]    mode_wdata,
    input logic [2:0]    mode_q,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] data_q,
    input rd_state_e     st_q
);
    localparam int GW = $clog2(LOW_MIN + 1);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      gap_q <= GW'(LOW_MIN);
        else if (data_q[DW-1])           gap_q <= '0;
        else if (gap_q != GW'(LOW_MIN))  gap_q <= gap_q + 1'b1;
    end

    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel_n && qual_a && qual_b) |=> mode_q == $past(mode_wdata));

    p_mode_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_sel_n && qual_a && qual_b) |=> $stable(mode_q));

    p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_sel_n && !qual_a && !qual_b) |-> rd_data == '0);

    p_msb_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_q[DW-1]) |-> gap_q >= GW'(LOW_MIN));

    p_load_from_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_q) && data_q != '0) |-> (data_q[DW-1] && $past(data_q) == '0));

    p_valid_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_VALID || st_q == ST_HOLD) |-> data_q[DW-1]);
endmodule

bind disk_rdreg rdreg_chk #(.DW(DW), .LOW_MIN(LOW_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_sel_n(dev_sel_n), .qual_a(qual_a),
    .qual_b(qual_b), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .rd_data(rd_data), .data_q(data_q), .st_q(st_q)
);

// File: tb/tb_disk_rdreg.sv
module tb_disk_rdreg;
    localparam int CLK_NS    = 10;
    localparam int LOW_MIN   = 6;
    localparam int HOLD_CYC  = 8;
    localparam int FAST_SLOT = 7;
    localparam int SLOW_SLOT = 14;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rd_serial = 1'b1, dev_sel_n = 1'b1, qual_a = 1'b0, qual_b = 1'b0;
    logic [2:0] mode_wdata = 3'd0;
    logic [7:0] rd_data;

    disk_rdreg #(.LOW_MIN(LOW_MIN), .HOLD_CYC(HOLD_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .rd_serial(rd_serial), .dev_sel_n(dev_sel_n),
        .qual_a(qual_a), .qual_b(qual_b), .mode_wdata(mode_wdata), .rd_data(rd_data)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    logic [7:0] expq[$];
    logic [7:0] exp_b;
    bit   mon_en = 1'b0, prev_msb = 1'b0;
    int   gap_cnt = LOW_MIN, last_gap = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: one expected byte per rise of bit 7
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            prev_msb = 1'b0;
            gap_cnt  = LOW_MIN;
        end else begin
            if (rd_data[7] && !prev_msb && mon_en) begin
                last_gap = gap_cnt;
                if (expq.size() == 0) check(1'b0, "R4", "unexpected byte", rd_data, 0);
                else begin
                    exp_b = expq.pop_front();
                    check(rd_data == exp_b, "R4", "scoreboard byte", rd_data, exp_b);
                end
                check(gap_cnt >= LOW_MIN, "R8", "msb low time", gap_cnt, LOW_MIN);
            end
            if (rd_data[7]) gap_cnt = 0;
            else            gap_cnt++;
            prev_msb = rd_data[7];
        end
    end

    // all driver tasks start and end at a negative edge
    task automatic send_bit(input logic b, input int slot);
        rd_serial = ~b;
        repeat (2) @(negedge clk);
        rd_serial = 1'b1;
        repeat (slot - 2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int top, input int slot);
        for (int i = top; i >= 0; i--) send_bit(v[i], slot);
    endtask

    task automatic send_byte(input logic [7:0] v, input int slot);
        expq.push_back(v);
        send_bits(v, 7, slot);
    endtask

    task automatic wr_mode(input logic [2:0] v);
        dev_sel_n = 1'b0; qual_a = 1'b1; qual_b = 1'b1; mode_wdata = v;
        #1 check(rd_data == 8'h00, "R3", "bus quiet during mode write", rd_data, 0);
        @(negedge clk);
        dev_sel_n = 1'b1; qual_a = 1'b0; qual_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic select_quiet();
        mon_en = 1'b0; dev_sel_n = 1'b0; qual_a = 1'b0; qual_b = 1'b0;
        repeat (2) @(negedge clk);
        mon_en = 1'b1;
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00, "R1", "reset output deselected", rd_data, 0);
        dev_sel_n = 1'b0;
        #1 check(rd_data == 8'h00, "R1", "reset data register empty", rd_data, 0);
        @(negedge clk);

        // R5: slow timing base from reset mode, port operation
        select_quiet();
        send_byte(8'hB7, SLOW_SLOT);
        send_byte(8'hC9, SLOW_SLOT);
        repeat (60) @(negedge clk);
        check(expq.size() == 0, "R5", "slow mode bytes delivered", expq.size(), 0);

        // fast, asynchronous, latch off
        mon_en = 1'b0; dev_sel_n = 1'b1;
        @(negedge clk);
        wr_mode(3'b110);
        dev_sel_n = 1'b0; qual_a = 1'b1;
        #1 check(rd_data == 8'h00, "R3", "bus quiet with qualifier a set", rd_data, 0);
        select_quiet();
        send_byte(8'hD5, FAST_SLOT);
        send_byte(8'hAA, FAST_SLOT);
        send_byte(8'h96, FAST_SLOT);
        send_byte(8'hFF, FAST_SLOT);
        send_byte(8'h81, FAST_SLOT);
        repeat (80) @(negedge clk);
        check(expq.size() == 0, "R4", "fast stream delivered", expq.size(), 0);

        // R2: qualifier pair 10 must not write the mode (slow) register
        mon_en = 1'b0; qual_a = 1'b1; qual_b = 1'b0; mode_wdata = 3'b010;
        @(negedge clk);
        select_quiet();
        send_byte(8'hE6, FAST_SLOT);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R2", "mode kept fast after non-write", expq.size(), 0);

        // R7 and R4 latency: first 1 of next byte clears the held byte
        expq.push_back(8'hA5);
        rd_serial = 1'b0;
        repeat (2) @(negedge clk);
        rd_serial = 1'b1;
        check(rd_data == 8'hE6, "R7", "held before third edge", rd_data, 8'hE6);
        @(negedge clk);
        check(rd_data == 8'h00, "R7", "cleared at shift start", rd_data, 0);
        repeat (FAST_SLOT - 3) @(negedge clk);
        send_bits(8'hA5, 6, FAST_SLOT);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R4", "byte after clear delivered", expq.size(), 0);

        // latch policy: a read of the held byte starts a hold and clears it
        mon_en = 1'b0; dev_sel_n = 1'b1;
        @(negedge clk);
        wr_mode(3'b111);
        dev_sel_n = 1'b0;
        repeat (HOLD_CYC + 4) @(negedge clk);
        check(rd_data == 8'h00, "R6", "held byte cleared after hold", rd_data, 0);
        mon_en = 1'b1;

        // R9: overwrite of an unread byte, exact low gap
        send_byte(8'h9B, FAST_SLOT);
        send_byte(8'hCD, FAST_SLOT);
        repeat (30) @(negedge clk);
        check(expq.size() == 0, "R9", "both bytes seen", expq.size(), 0);
        check(last_gap == LOW_MIN, "R9", "overwrite low gap", last_gap, LOW_MIN);

        // R6: hold length measured from the first edge of the read
        mon_en = 1'b0; dev_sel_n = 1'b1;
        @(negedge clk);
        dev_sel_n = 1'b0;
        repeat (HOLD_CYC) @(negedge clk);
        check(rd_data == 8'hCD, "R6", "byte held through hold", rd_data, 8'hCD);
        @(negedge clk);
        check(rd_data == 8'h00, "R6", "byte cleared after hold", rd_data, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                check(1'b0, "WDOG", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule